// File: doc/BRIEF.md
# Dual-Encoding SPI Clock Prescaler

This block derives the serial clock of a SPI master from the system clock. An 8-bit prescale field, read as one of two encodings chosen by a mode input, sets the divisor. The block runs a half-period counter and emits a single-cycle toggle strobe at the end of each half period. It also drives the serial clock level, the divisor now in use, and a flag that marks an unusable setting.

The compact encoding covers even divisors from 4 to 30, with an offset in the upper bit of a 5-bit value. The wide encoding multiplies a 4-bit factor by a power of two, and its 3-bit exponent is split over non-adjacent field bits. Finding the setting closest to a target rate is left to software.

A new setting is taken only at the end of a full serial clock period, so no shortened pulse reaches the bus. While the setting is invalid the clock is stopped, and any valid setting is accepted on the next edge.

Top module: `spi_prescaler`

## Requirements
- R1: With `ext_mode`=0, only `prescale[4:0]` is used. A value V from 0x12 to 0x1F gives divisor 2*(V-0x10), so 0x12 gives 4 and 0x1F gives 30. Bits 7:5 have no effect.
- R2: With `ext_mode`=0, any `prescale[4:0]` below 0x12 is invalid. `invalid` is 1 and `divisor` is 0.
- R3: With `ext_mode`=1, the factor F is `prescale[3:0]` and the exponent E is {`prescale[7]`,`prescale[6]`,`prescale[4]`}, with bit 4 as the LSB. The divisor is F*2^E. Bit 5 has no effect.
- R4: With `ext_mode`=1, a setting with F=0, or with F=1 and E=0, is invalid. `invalid` is 1 and `divisor` is 0, so a valid divisor is never below 2.
- R5: While `invalid` is 1, `sck` stays 0 and `sck_tgl` stays 0.
- R6: For a valid divisor D, `sck` is low for floor(D/2) cycles and then high for ceil(D/2) cycles. Each period starts with the low phase, and an odd divisor gives the extra cycle to the high phase.
- R7: `sck_tgl` is 1 in the last cycle of each phase and only then. `sck` inverts on the following edge and holds its value otherwise.
- R8: A setting change while the clock runs takes effect only at the clock edge that ends a high phase. Until that edge, `divisor` and the phase lengths stay unchanged. While invalid, the setting is read again on every edge.
- R9: While `rst_n` is 0, `sck`=0, `sck_tgl`=0, `invalid`=1 and `divisor`=0. The setting is taken at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode | input | 1 | 0 selects the compact encoding, 1 the wide encoding |
| prescale | input | 8 | Prescale field |
| sck | output | 1 | Serial clock level, idle low |
| sck_tgl | output | 1 | One-cycle strobe in the last cycle of each half period |
| divisor | output | 11 | Divisor in use, 0 when invalid |
| invalid | output | 1 | The setting in use is not valid and the clock is stopped |

## Verification
A wrongly decoded or wrongly latched setting shows up on `divisor` one edge after it is taken. A counter that is off by one shows in the length of the very next phase of `sck` and in where `sck_tgl` falls. A setting taken too early shows as a phase whose length matches neither the old divisor nor the new one, within the same period.

The bench decodes every field value in both encodings and measures one full period of each. It also changes the setting in the middle of a period and checks where the change takes effect.

// File: rtl/spi_prescaler.sv
module spi_prescaler #(
  parameter int FIELD_W = 8,
  parameter int FACT_W  = 4,
  parameter int EXP_W   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ext_mode,
  input  logic [FIELD_W-1:0]                   prescale,
  output logic                                 sck,
  output logic                                 sck_tgl,
  output logic [FACT_W+(1<<EXP_W)-2:0]         divisor,
  output logic                                 invalid
);
  localparam int DIV_W = FACT_W + (1 << EXP_W) - 1;

  logic [3:0]        leg_half;
  logic              leg_bad, ext_bad, dec_bad;
  logic [FACT_W-1:0] fac;
  logic [EXP_W-1:0]  expo;
  logic [DIV_W-1:0]  leg_div, ext_div, dec_div;

  assign leg_half = prescale[3:0];
  assign leg_bad  = !prescale[4] || (leg_half < 4'd2);
  assign leg_div  = DIV_W'(leg_half) << 1;

  assign fac     = prescale[FACT_W-1:0];
  assign expo    = {prescale[7:6], prescale[4]};
  assign ext_div = DIV_W'(fac) << expo;
  assign ext_bad = (fac == '0) || ((fac == FACT_W'(1)) && (expo == '0));

  assign dec_bad = ext_mode ? ext_bad : leg_bad;
  assign dec_div = dec_bad ? '0 : (ext_mode ? ext_div : leg_div);

  logic [DIV_W-1:0] cnt, half_lo, half_hi, plen;

  assign half_lo = divisor >> 1;
  assign half_hi = divisor - half_lo;
  assign plen    = sck ? half_hi : half_lo;
  assign sck_tgl = !invalid && (cnt == plen - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor <= '0;
      invalid <= 1'b1;
      cnt     <= '0;
      sck     <= 1'b0;
    end else if (invalid) begin
      divisor <= dec_div;
      invalid <= dec_bad;
      cnt     <= '0;
      sck     <= 1'b0;
    end else if (sck_tgl) begin
      cnt <= '0;
      sck <= !sck;
      if (sck) begin
        divisor <= dec_div;
        invalid <= dec_bad;
      end
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_prescaler_chk.sv
module spi_prescaler_chk #(
  parameter int DIV_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic             sck_tgl,
  input logic             invalid,
  input logic [DIV_W-1:0] divisor
);
  logic [DIV_W:0] run;
  logic [DIV_W:0] want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (invalid || sck_tgl) run <= '0;
    else run <= run + 1'b1;
  end

  assign want = sck ? ({1'b0, divisor} - ({1'b0, divisor} >> 1)) : ({1'b0, divisor} >> 1);

  AST_QUIET_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n) invalid |-> (!sck && !sck_tgl)); // R5
  AST_MIN_DIV: assert property (@(posedge clk) disable iff (!rst_n) !invalid |-> (divisor >= DIV_W'(2))); // R4
  AST_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n) (sck_tgl && !invalid) |-> (run + 1'b1 == want)); // R6
  AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n) sck_tgl |=> (sck != $past(sck))); // R7
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sck_tgl |=> $stable(sck)); // R7
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!invalid && !(sck && sck_tgl)) |=> $stable(divisor)); // R8
endmodule

bind spi_prescaler spi_prescaler_chk #(.DIV_W(11)) u_chk (.*);

// File: tb/tb_spi_prescaler.sv
module tb_spi_prescaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic [7:0]  prescale = 8'h00;
  logic        sck, sck_tgl, invalid;
  logic [10:0] divisor;

  int checks = 0;
  int fails  = 0;

  always #4 clk = !clk;

  spi_prescaler dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .prescale(prescale),
    .sck(sck), .sck_tgl(sck_tgl), .divisor(divisor), .invalid(invalid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_div(input bit m, input logic [7:0] f);
    int v, fac, e, d;
    if (!m) begin
      v = int'(f[4:0]);
      return (v < 18) ? 0 : 2 * (v - 16);
    end
    fac = int'(f[3:0]);
    e   = int'({f[7], f[6], f[4]});
    d   = fac << e;
    return (d < 2) ? 0 : d;
  endfunction

  task automatic run_cfg(input bit m, input logic [7:0] f);
    int d, lo, hi, tlo, thi;
    bit lastlo, lasthi, bad;
    string rq;
    d  = exp_div(m, f);
    rq = m ? ((d == 0) ? "R4" : "R3") : ((d == 0) ? "R2" : "R1");
    ext_mode = m;
    prescale = f;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(invalid && !sck && !sck_tgl && divisor == 0, "R9", int'(divisor), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(divisor) == d, rq, int'(divisor), d);
    chk(invalid == (d == 0), rq, int'(invalid), int'(d == 0));
    if (d == 0) begin
      bad = 1'b0;
      repeat (40) begin
        if (sck || sck_tgl) bad = 1'b1;
        @(negedge clk);
      end
      chk(!bad, "R5", int'(bad), 0);
    end else begin
      lo = 0; tlo = 0; lastlo = 1'b0;
      while (!sck && lo < 4000) begin
        lo++; tlo += int'(sck_tgl); lastlo = sck_tgl;
        @(negedge clk);
      end
      hi = 0; thi = 0; lasthi = 1'b0;
      while (sck && hi < 4000) begin
        hi++; thi += int'(sck_tgl); lasthi = sck_tgl;
        @(negedge clk);
      end
      chk(lo == d / 2, "R6 low", lo, d / 2);
      chk(hi == (d + 1) / 2, "R6 high", hi, (d + 1) / 2);
      chk(tlo == 1 && thi == 1 && lastlo && lasthi, "R7", tlo + thi, 2);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n, lo, hi;
    bit bad;
    @(negedge clk);
    chk(invalid && !sck && !sck_tgl && divisor == 0, "R9 reset", int'(divisor), 0);

    for (int f = 0; f < 256; f++) run_cfg(1'b0, 8'(f));
    for (int f = 0; f < 256; f++) run_cfg(1'b1, 8'(f));

    // R8: change in mid-period, change to invalid, recover
    ext_mode = 1'b0; prescale = 8'h12;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n = 0;
    while (!sck && n < 100) begin n++; @(negedge clk); end
    ext_mode = 1'b1; prescale = 8'h45;
    n = 0; bad = 1'b0;
    while (sck && n < 100) begin
      n++;
      if (divisor != 11'd4) bad = 1'b1;
      @(negedge clk);
    end
    chk(n == 2, "R8 old high phase", n, 2);
    chk(!bad, "R8 old divisor held", int'(bad), 0);
    chk(divisor == 11'd20, "R8 new divisor", int'(divisor), 20);
    prescale = 8'h00;
    lo = 0; bad = 1'b0;
    while (!sck && lo < 100) begin
      lo++;
      if (invalid || divisor != 11'd20) bad = 1'b1;
      @(negedge clk);
    end
    hi = 0;
    while (sck && hi < 100) begin
      hi++;
      if (invalid || divisor != 11'd20) bad = 1'b1;
      @(negedge clk);
    end
    chk(lo == 10, "R8 new low", lo, 10);
    chk(hi == 10, "R8 new high", hi, 10);
    chk(!bad, "R8 held until period end", int'(bad), 0);
    chk(invalid && divisor == 0, "R8 invalid at period end", int'(invalid), 1);
    ext_mode = 1'b0; prescale = 8'h12;
    @(negedge clk);
    chk(!invalid && divisor == 11'd4, "R8 recovery", int'(divisor), 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule